// File: doc/BRIEF.md
# Flash Program Write Buffer with Forced Flush

This block gathers one wide flash program word from a series of narrow bus writes and passes each finished word to a downstream operation queue. The word is split into beats. Each beat is written with a beat index, a data value and per-byte enables. Every byte carries a written flag, so the buffer always knows which bytes hold data and which have never been touched. Bytes that were never written always read as all ones.

The buffer accepts data only while the program-enable input is high. When that input goes low, any bytes not yet offered to the queue are thrown away. A word is offered to the queue on its own once every byte is written. Software can also raise a force request that flushes a partly filled word. The missing bytes go out as ones. The force flag clears itself when the queue acknowledges the word, and it has no effect on an empty buffer. An offered word is held unchanged until the queue accepts it. The buffer then returns to empty. The buffer has no erase input, so buffered writes can be prepared while an erase runs elsewhere.

Top module: `pgm_wbuf`

## Requirements
- R1: After reset, `q_valid` and `force_pend` are 0, `buf_empty` is 1, `buf_full` is 0 and `q_data` is all ones.
- R2: A write with `wr_valid`=1 is taken when `prog_en`=1 and no word is pending. Beat `i` maps to `q_data[i*32 +: 32]`, and byte enable bit `b` maps to bits `b*8 +: 8` of that beat. Enabled bytes take `wr_data` on the next clock edge, and bytes never written read as 0xFF. `buf_empty` falls once any byte has been written.
- R3: While `prog_en`=0, writes are ignored: `q_data` stays all ones and `buf_empty` stays 1.
- R4: When the last byte of the word is written, `buf_full` goes to 1 on that edge, and `q_valid` rises on the following edge without any force request.
- R5: While `q_valid`=1 and `q_ready`=0, `q_data`, `buf_full` and `q_valid` hold their values, and any write is ignored.
- R6: On an edge with `q_valid`=1 and `q_ready`=1, the buffer returns to empty: `q_valid` and `force_pend` are 0, `buf_empty` is 1 and `q_data` is all ones.
- R7: A one-cycle `force_req` sets `force_pend` on its edge. If the buffer holds at least one written byte, `q_valid` rises on the next edge, `buf_full` reads 1, and every unwritten byte is sent as 0xFF.
- R8: `force_pend` stays 1 while the forced word waits and clears on the acknowledge edge.
- R9: A force request on an empty buffer clears `force_pend` on the following edge and starts no word. Repeating the request starts no word either.
- R10: Dropping `prog_en` to 0 while no word is pending discards the buffer on the next edge: `buf_empty` becomes 1, `q_data` all ones and `force_pend` 0.
- R11: Dropping `prog_en` while a word is pending does not change the pending word or `q_valid`.
- R12: Writing a byte that is already written replaces its value with the newer one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Program enable; low discards unqueued data |
| wr_valid | input | 1 | Beat write strobe |
| wr_idx | input | 3 | Beat index within the word |
| wr_be | input | 4 | Byte enables of the beat |
| wr_data | input | 32 | Beat data |
| force_req | input | 1 | Request to flush a partial word |
| force_pend | output | 1 | Force flag, cleared on acknowledge or on an empty buffer |
| q_valid | output | 1 | Word offered to the operation queue |
| q_ready | input | 1 | Queue acknowledge |
| q_data | output | 256 | Buffered word, unwritten bytes as ones |
| buf_empty | output | 1 | No byte written |
| buf_full | output | 1 | Every byte written or padded |

## Verification
Random beat orders with random byte enables fill words up to an automatic hand-off. This separates correct per-byte tracking from per-beat tracking, because a beat with sparse enables must not count as complete. Random early force requests flush partial words and check the 0xFF padding against a bench model of the written bytes. Force requests on an empty buffer check that the force flag clears without launching a word. Directed cases cover disabling while idle and while a word is pending, writes during a pending word and with the enable low, and overwriting a byte. Together these tell discard apart from hold, and ignored writes apart from accepted ones.

// File: rtl/pgm_wbuf.sv
module pgm_wbuf #(
  parameter int WORD_W = 256,
  parameter int BEAT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_en,
  input  logic                          wr_valid,
  input  logic [$clog2(WORD_W/BEAT_W)-1:0] wr_idx,
  input  logic [BEAT_W/8-1:0]           wr_be,
  input  logic [BEAT_W-1:0]             wr_data,
  input  logic                          force_req,
  output logic                          force_pend,
  output logic                          q_valid,
  input  logic                          q_ready,
  output logic [WORD_W-1:0]             q_data,
  output logic                          buf_empty,
  output logic                          buf_full
);
  localparam int BEATS = WORD_W / BEAT_W;
  localparam int LANES = BEAT_W / 8;
  localparam int BYTES = WORD_W / 8;
  localparam int IDX_W = $clog2(BEATS);

  logic [WORD_W-1:0] word_q;
  logic [BYTES-1:0]  mask_q;
  logic              vld_q;
  logic              frc_q;

  wire empty = ~|mask_q;
  wire full  = &mask_q;
  wire done  = vld_q & q_ready;
  wire drop  = ~prog_en & ~vld_q;
  wire issue = prog_en & ~vld_q & (full | (frc_q & ~empty));
  wire take  = prog_en & wr_valid & ~vld_q & ~issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '1;
      mask_q <= '0;
      vld_q  <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      if (done || drop) begin
        word_q <= '1;
        mask_q <= '0;
      end else if (issue) begin
        mask_q <= '1;
      end else if (take) begin
        for (int i = 0; i < BEATS; i++) begin
          for (int b = 0; b < LANES; b++) begin
            if (wr_idx == IDX_W'(i) && wr_be[b]) begin
              word_q[i*BEAT_W + b*8 +: 8] <= wr_data[b*8 +: 8];
              mask_q[i*LANES + b]         <= 1'b1;
            end
          end
        end
      end

      if (done)
        vld_q <= 1'b0;
      else if (issue)
        vld_q <= 1'b1;

      if (done || drop)
        frc_q <= 1'b0;
      else if (frc_q && empty && !vld_q)
        frc_q <= 1'b0;
      else if (force_req)
        frc_q <= 1'b1;
    end
  end

  assign q_data     = word_q;
  assign q_valid    = vld_q;
  assign force_pend = frc_q;
  assign buf_empty  = empty;
  assign buf_full   = full;
endmodule

// File: rtl/pgm_wbuf_chk.sv
module pgm_wbuf_chk #(
  parameter int WORD_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic              force_req,
  input logic              force_pend,
  input logic              q_valid,
  input logic              q_ready,
  input logic [WORD_W-1:0] q_data,
  input logic              buf_empty,
  input logic              buf_full
);
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_data) && buf_full); // R5
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> !q_valid && buf_empty && !force_pend && (&q_data)); // R6
  AST_FULL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en && !q_valid && buf_full |=> q_valid); // R4
  AST_FORCE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en && !q_valid && force_pend && !buf_empty |=> q_valid && buf_full); // R7
  AST_EMPTY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    force_pend && buf_empty && !q_valid |=> !q_valid && !force_pend); // R9
  AST_FORCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    force_pend && q_valid && !q_ready |=> force_pend); // R8
  AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en && !q_valid |=> buf_empty && !force_pend); // R10
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en && q_valid && !q_ready |=> q_valid); // R11
  AST_EMPTY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> (&q_data) && !buf_full && !q_valid); // R2
endmodule

bind pgm_wbuf pgm_wbuf_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/pgm_wbuf_test.sv
`timescale 1ns/1ps
module pgm_wbuf_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prog_en = 1'b0;
  logic         wr_valid = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic [3:0]   wr_be = '0;
  logic [31:0]  wr_data = '0;
  logic         force_req = 1'b0;
  logic         force_pend;
  logic         q_valid;
  logic         q_ready = 1'b0;
  logic [255:0] q_data;
  logic         buf_empty;
  logic         buf_full;

  int checks = 0;
  int errors = 0;
  logic [255:0] exp_word;
  logic [31:0]  exp_mask;

  always #2 clk = ~clk;

  pgm_wbuf uut (.*);

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d, input logic [3:0] be);
    wr_idx = idx; wr_data = d; wr_be = be; wr_valid = 1'b1;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic frc();
    force_req = 1'b1;
    step();
    force_req = 1'b0;
  endtask

  task automatic ack();
    q_ready = 1'b1;
    step();
    q_ready = 1'b0;
  endtask

  function automatic logic [255:0] model_word(logic [255:0] w, logic [2:0] idx,
                                                logic [31:0] d, logic [3:0] be);
    logic [255:0] r = w;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[int'(idx)*32 + b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_mask(logic [31:0] m, logic [2:0] idx, logic [3:0] be);
    logic [31:0] r = m;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[int'(idx)*4 + b] = 1'b1;
    return r;
  endfunction

  task automatic model_clear();
    exp_word = '1;
    exp_mask = '0;
  endtask

  task automatic mwr(input logic [2:0] idx, input logic [31:0] d, input logic [3:0] be);
    wr(idx, d, be);
    exp_word = model_word(exp_word, idx, d, be);
    exp_mask = model_mask(exp_mask, idx, be);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [255:0] held;
    void'($urandom(32'h5eed_1234));
    model_clear();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 q_valid", q_valid, 0);
    chk("R1 force_pend", force_pend, 0);
    chk("R1 empty/full", {buf_empty, buf_full}, 2'b10);
    chk("R1 q_data", q_data, '1);

    wr(3'd2, 32'h1234_5678, 4'hF);
    chk("R3 disabled write q_data", q_data, '1);
    chk("R3 disabled write empty", buf_empty, 1);

    prog_en = 1'b1;
    mwr(3'd1, 32'hA1B2_C3D4, 4'b0101);
    chk("R2 sparse bytes", q_data, exp_word);
    chk("R2 empty low", buf_empty, 0);
    mwr(3'd1, 32'h0000_9900, 4'b0011);
    chk("R12 overwrite", q_data, exp_word);

    prog_en = 1'b0;
    step();
    prog_en = 1'b1;
    model_clear();
    chk("R10 discard data", q_data, '1);
    chk("R10 discard empty", buf_empty, 1);

    frc();
    chk("R9 force flag set", force_pend, 1);
    step();
    chk("R9 force clears", force_pend, 0);
    chk("R9 no launch", q_valid, 0);
    frc();
    step();
    chk("R9 repeat no launch", {q_valid, force_pend}, 2'b00);

    for (int i = 0; i < 8; i++) mwr(3'(i), $urandom, 4'hF);
    chk("R4 full before launch", {buf_full, q_valid}, 2'b10);
    step();
    chk("R4 auto launch", q_valid, 1);
    chk("R4 word", q_data, exp_word);
    held = q_data;
    wr(3'd0, 32'hDEAD_BEEF, 4'hF);
    chk("R5 write ignored while pending", q_data, held);
    prog_en = 1'b0;
    step();
    chk("R11 pending kept", {q_valid, buf_full}, 2'b11);
    chk("R11 data kept", q_data, held);
    prog_en = 1'b1;
    ack();
    model_clear();
    chk("R6 after ack", {q_valid, buf_empty, force_pend}, 3'b010);
    chk("R6 data ones", q_data, '1);

    mwr(3'd7, 32'h0102_0304, 4'b1000);
    frc();
    chk("R7 force flag", {force_pend, q_valid}, 2'b10);
    step();
    chk("R7 forced launch", {q_valid, buf_full}, 2'b11);
    chk("R7 padded word", q_data, exp_word);
    step();
    chk("R8 flag held", force_pend, 1);
    ack();
    model_clear();
    chk("R8 flag cleared on ack", force_pend, 0);

    for (int w = 0; w < 60; w++) begin
      bit forced = 0;
      while (exp_mask != '1 && !forced) begin
        mwr(3'($urandom_range(0, 7)), $urandom, 4'($urandom_range(0, 15)));
        chk("R2 random fill", q_data, exp_word);
        chk("R2 random empty", buf_empty, exp_mask == '0);
        if (exp_mask != '1 && $urandom_range(0, 9) == 0) forced = 1;
      end
      if (forced) begin
        frc();
        step();
        if (exp_mask == '0) begin
          chk("R9 random empty force", {q_valid, force_pend}, 2'b00);
          continue;
        end
        chk("R7 random forced launch", q_valid, 1);
      end else begin
        chk("R4 random full no valid yet", q_valid, 0);
        step();
        chk("R4 random launch", q_valid, 1);
      end
      chk("R7 random word", q_data, exp_word);
      for (int h = 0; h < int'($urandom_range(0, 3)); h++) begin
        step();
        chk("R5 random hold", {q_valid, q_data}, {1'b1, exp_word});
      end
      ack();
      model_clear();
      chk("R6 random ack", {q_valid, buf_empty}, 2'b01);
    end
    finish_run();
  end
endmodule